// File: doc/BRIEF.md
# Stepped-Voltage Resistive Memory Pulse Sequencer

This block takes one resistive memory cell through a FORM, SET or RESET operation. Each attempt is a timed programming pulse followed by a verify read. It issues digital level codes for the word line, bit line and source line, a strobe that marks the pulse and a strobe that marks the verify read. Analog drivers, DACs and the sense amplifier sit outside the block. The only thing it reads back from them is a comparator pass bit.

When an attempt fails, the amplitudes climb as a nested two-rail ramp. The word-line code is the inner loop. The second rail is the outer loop: the bit line for FORM and SET, the source line for RESET. A fixed single-level mode instead repeats one pulse, with a verify after each attempt, up to a try limit.

Commands arrive over a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a command is running, `cmd_ready` stays low and a waiting requester simply holds its command. The block applies no other back-pressure.

Top module: `rram_pulse_seq`

## Requirements
- R1: A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only in idle. A command presented while busy changes nothing in the operation under way.
- R2: Level codes are unsigned, in units of 0.1 V. During a pulse, `wl_code` carries the word-line level. For FORM (op 0) and SET (op 1), `bl_code` carries the second rail and `sl_code` is 0. For RESET (op 2), `sl_code` carries the second rail and `bl_code` is 0. Op 3 behaves as SET.
- R3: After a failed verify, the word-line code rises by 1 for the next pulse while the second rail holds.
- R4: After a failed verify with the word-line code at its maximum, the second rail rises by 1 and the word-line code restarts at its minimum.
- R5: After a failed verify with both rails at their maxima, the block raises `fail`, issues no further pulse and holds all three codes at 0.
- R6: With `cmd_custom`=0, the ramp fields are ignored and these defaults apply:
  - FORM: word line 14..25, bit line 24..33.
  - SET: word line 17, bit line 24.
  - RESET: word line 25, source line 26.
  - Pulse width: `DEF_PULSE_CYCLES` cycles, which is 250, or 1000 ns at 4 ns.
- R7: With `cmd_custom`=1, the ramp bounds come from the command fields and the pulse width from `cmd_pulse_cycles`. A width of 0 counts as 1. This covers short 25..50 cycle (100..200 ns) pulses.
- R8: `pulse_en` stays high for exactly the pulse width, and the level codes are stable throughout.
- R9: Every pulse is followed at once by `verify_en` for `VERIFY_CYCLES` cycles, with all codes at 0. The pass bit is sampled on the last verify cycle. A pass raises `done` and ends the operation.
- R10: All three codes are 0 for at least one cycle before every pulse.
- R11: With `cmd_fixed`=1, every pulse uses the minimum levels. The block fails after `cmd_tries` failed attempts, where 0 counts as 1.
- R12: `done` and `fail` stay high from completion until the next accepted command. `cell_addr` shows the address of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Sequencer idle, command can transfer |
| cmd_op | input | 2 | 0 FORM, 1 SET, 2 RESET |
| cmd_addr | input | ADDR_W | Cell address |
| cmd_custom | input | 1 | Use command ramp fields instead of defaults |
| cmd_fixed | input | 1 | Fixed single-level repeat mode |
| cmd_wl_min | input | LVL_W | Word-line lower bound |
| cmd_wl_max | input | LVL_W | Word-line upper bound |
| cmd_rail_min | input | LVL_W | Second-rail lower bound |
| cmd_rail_max | input | LVL_W | Second-rail upper bound |
| cmd_pulse_cycles | input | PW_W | Custom pulse width in cycles |
| cmd_tries | input | TRY_W | Attempt limit in fixed mode |
| verify_pass | input | 1 | Comparator pass bit |
| wl_code | output | LVL_W | Word-line level code |
| bl_code | output | LVL_W | Bit-line level code |
| sl_code | output | LVL_W | Source-line level code |
| pulse_en | output | 1 | Programming pulse strobe |
| verify_en | output | 1 | Verify read strobe |
| cell_addr | output | ADDR_W | Address of the current operation |
| done | output | 1 | Operation passed |
| fail | output | 1 | Operation gave up |

## Verification
The bench targets these cases:

- **Word-line wrap at its maximum.** It drives the default FORM ramp to its thirteenth pulse, where the inner loop wraps. A design that mishandles the wrap would keep climbing past 25 or fail to raise the bit line.
- **Exhausting the ramp.** It exhausts a small two-by-two ramp. An off-by-one in the end test would show up as a missing or extra fourth pulse.
- **RESET rail mapping.** It runs RESET with a ramp. Swapped rails would put the stepped level on the bit line.
- **Fixed mode.** It runs fixed mode against the try limit. A stray step would move the levels away from the minimum.
- **Command while busy.** It presents a command in the middle of an operation. A design that accepted it would change op or levels partway through.
- **Timing of every pulse.** For every pulse, the bench checks the width, the idle gap before it and a verify read starting at once afterwards.

// File: rtl/rram_seq_pkg.sv
package rram_seq_pkg;

  typedef enum logic [1:0] {
    OP_FORM  = 2'd0,
    OP_SET   = 2'd1,
    OP_RESET = 2'd2,
    OP_RSVD  = 2'd3
  } prog_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GAP    = 2'd1,
    PH_PULSE  = 2'd2,
    PH_VERIFY = 2'd3
  } phase_e;

endpackage

// File: rtl/rram_phase_timer.sv
module rram_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == '0);

  // R8: a running phase counts down one per cycle
  assert_timer_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/rram_rail_stepper.sv
module rram_rail_stepper #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [LVL_W-1:0] wl_lo,
  input  logic [LVL_W-1:0] wl_hi,
  input  logic [LVL_W-1:0] sec_lo,
  input  logic [LVL_W-1:0] sec_hi,
  output logic [LVL_W-1:0] wl_lvl,
  output logic [LVL_W-1:0] sec_lvl,
  output logic             last_point
);

  logic [LVL_W-1:0] wl_min_q, wl_max_q, sec_max_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_lvl    <= '0;
      sec_lvl   <= '0;
      wl_min_q  <= '0;
      wl_max_q  <= '0;
      sec_max_q <= '0;
    end else if (init) begin
      wl_lvl    <= wl_lo;
      sec_lvl   <= sec_lo;
      wl_min_q  <= wl_lo;
      wl_max_q  <= wl_hi;
      sec_max_q <= sec_hi;
    end else if (step) begin
      if (wl_lvl < wl_max_q) begin
        wl_lvl <= wl_lvl + LVL_W'(1);
      end else begin
        wl_lvl <= wl_min_q;
        if (sec_lvl < sec_max_q) sec_lvl <= sec_lvl + LVL_W'(1);
      end
    end
  end

  assign last_point = (wl_lvl >= wl_max_q) && (sec_lvl >= sec_max_q);

  // R3: inner loop advances the word line, second rail holds
  assert_inner_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init && wl_lvl < wl_max_q) |=>
      (wl_lvl == $past(wl_lvl) + LVL_W'(1)) && $stable(sec_lvl));

  // R4: word line wraps to its minimum while the second rail advances
  assert_outer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init && wl_lvl >= wl_max_q && sec_lvl < sec_max_q) |=>
      (wl_lvl == wl_min_q) && (sec_lvl == $past(sec_lvl) + LVL_W'(1)));

endmodule

// File: rtl/rram_pulse_seq.sv
module rram_pulse_seq
  import rram_seq_pkg::*;
#(
  parameter int ADDR_W           = 10,
  parameter int LVL_W            = 6,
  parameter int PW_W             = 12,
  parameter int TRY_W            = 8,
  parameter int VERIFY_CYCLES    = 4,
  parameter int DEF_PULSE_CYCLES = 250,
  parameter int DEF_FORM_WL_LO   = 14,
  parameter int DEF_FORM_WL_HI   = 25,
  parameter int DEF_FORM_BL_LO   = 24,
  parameter int DEF_FORM_BL_HI   = 33,
  parameter int DEF_SET_WL       = 17,
  parameter int DEF_SET_BL       = 24,
  parameter int DEF_RST_WL       = 25,
  parameter int DEF_RST_SL       = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_custom,
  input  logic              cmd_fixed,
  input  logic [LVL_W-1:0]  cmd_wl_min,
  input  logic [LVL_W-1:0]  cmd_wl_max,
  input  logic [LVL_W-1:0]  cmd_rail_min,
  input  logic [LVL_W-1:0]  cmd_rail_max,
  input  logic [PW_W-1:0]   cmd_pulse_cycles,
  input  logic [TRY_W-1:0]  cmd_tries,
  input  logic              verify_pass,
  output logic [LVL_W-1:0]  wl_code,
  output logic [LVL_W-1:0]  bl_code,
  output logic [LVL_W-1:0]  sl_code,
  output logic              pulse_en,
  output logic              verify_en,
  output logic [ADDR_W-1:0] cell_addr,
  output logic              done,
  output logic              fail
);

  localparam int VW    = $clog2(VERIFY_CYCLES + 1);
  localparam int TMR_W = (PW_W > VW) ? PW_W : VW;

  phase_e              phase;
  prog_op_e            op_q;
  logic                fixed_q;
  logic [PW_W-1:0]     pw_q;
  logic [TRY_W-1:0]    tries_q, att_q;
  logic                done_q, fail_q;
  logic [ADDR_W-1:0]   addr_q;

  logic                accept;
  logic [LVL_W-1:0]    sel_wl_lo, sel_wl_hi, sel_sec_lo, sel_sec_hi;
  logic [PW_W-1:0]     sel_pw;
  logic                tmr_load, tmr_last;
  logic [TMR_W-1:0]    tmr_len;
  logic                step;
  logic [LVL_W-1:0]    cur_wl, cur_sec;
  logic                last_point;
  logic                give_up;

  assign accept = cmd_valid && (phase == PH_IDLE);

  // configuration select: command fields or per-operation defaults
  always_comb begin
    sel_wl_lo  = cmd_wl_min;
    sel_wl_hi  = cmd_wl_max;
    sel_sec_lo = cmd_rail_min;
    sel_sec_hi = cmd_rail_max;
    sel_pw     = cmd_pulse_cycles;
    if (!cmd_custom) begin
      sel_pw = PW_W'(DEF_PULSE_CYCLES);
      case (prog_op_e'(cmd_op))
        OP_FORM: begin
          sel_wl_lo  = LVL_W'(DEF_FORM_WL_LO);
          sel_wl_hi  = LVL_W'(DEF_FORM_WL_HI);
          sel_sec_lo = LVL_W'(DEF_FORM_BL_LO);
          sel_sec_hi = LVL_W'(DEF_FORM_BL_HI);
        end
        OP_RESET: begin
          sel_wl_lo  = LVL_W'(DEF_RST_WL);
          sel_wl_hi  = LVL_W'(DEF_RST_WL);
          sel_sec_lo = LVL_W'(DEF_RST_SL);
          sel_sec_hi = LVL_W'(DEF_RST_SL);
        end
        default: begin
          sel_wl_lo  = LVL_W'(DEF_SET_WL);
          sel_wl_hi  = LVL_W'(DEF_SET_WL);
          sel_sec_lo = LVL_W'(DEF_SET_BL);
          sel_sec_hi = LVL_W'(DEF_SET_BL);
        end
      endcase
    end
  end

  assign tmr_load = (phase == PH_GAP) || (phase == PH_PULSE && tmr_last);
  assign tmr_len  = (phase == PH_GAP) ? TMR_W'(pw_q) : TMR_W'(VERIFY_CYCLES);

  rram_phase_timer #(.CNT_W(TMR_W)) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .len  (tmr_len),
    .last (tmr_last)
  );

  assign give_up = fixed_q ? (att_q >= tries_q) : last_point;
  assign step    = (phase == PH_VERIFY) && tmr_last && !verify_pass &&
                   !fixed_q && !last_point;

  rram_rail_stepper #(.LVL_W(LVL_W)) i_stepper (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (accept),
    .step      (step),
    .wl_lo     (sel_wl_lo),
    .wl_hi     (sel_wl_hi),
    .sec_lo    (sel_sec_lo),
    .sec_hi    (sel_sec_hi),
    .wl_lvl    (cur_wl),
    .sec_lvl   (cur_sec),
    .last_point(last_point)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      op_q    <= OP_FORM;
      fixed_q <= 1'b0;
      pw_q    <= '0;
      tries_q <= '0;
      att_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_GAP;
          op_q    <= prog_op_e'(cmd_op);
          fixed_q <= cmd_fixed;
          pw_q    <= sel_pw;
          tries_q <= cmd_tries;
          att_q   <= '0;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          addr_q  <= cmd_addr;
        end
        PH_GAP: begin
          phase <= PH_PULSE;
          if (att_q != '1) att_q <= att_q + TRY_W'(1);
        end
        PH_PULSE: if (tmr_last) phase <= PH_VERIFY;
        PH_VERIFY: if (tmr_last) begin
          if (verify_pass) begin
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end else if (give_up) begin
            phase  <= PH_IDLE;
            fail_q <= 1'b1;
          end else begin
            phase <= PH_GAP;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cmd_ready = (phase == PH_IDLE);
  assign pulse_en  = (phase == PH_PULSE);
  assign verify_en = (phase == PH_VERIFY);
  assign done      = done_q;
  assign fail      = fail_q;
  assign cell_addr = addr_q;

  always_comb begin
    wl_code = '0;
    bl_code = '0;
    sl_code = '0;
    if (phase == PH_PULSE) begin
      wl_code = cur_wl;
      if (op_q == OP_RESET) sl_code = cur_sec;
      else                  bl_code = cur_sec;
    end
  end

  // R1: a command offered while busy leaves the latched address alone
  assert_busy_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(cell_addr));

  // R2: one of the two outer rails is always grounded
  assert_one_rail_grounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |-> (bl_code == '0 || sl_code == '0));

  // R5: a failed operation leaves every rail at zero
  assert_fail_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!pulse_en && wl_code == '0 && bl_code == '0 && sl_code == '0));

  // R8: levels hold for the whole pulse
  assert_levels_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_en && $past(pulse_en)) |->
      ($stable(wl_code) && $stable(bl_code) && $stable(sl_code)));

  // R9: verify read follows each pulse at once
  assert_verify_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_en) |-> verify_en);

  // R10: idle rails in the cycle before a pulse
  assert_gap_before_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_en) |->
      ($past(wl_code) == '0 && $past(bl_code) == '0 && $past(sl_code) == '0));

  // R12: completion flags are exclusive
  assert_done_fail_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

// File: tb/test_rram_pulse_seq.sv
`timescale 1ns/1ps
module test_rram_pulse_seq;

  localparam int ADDR_W = 10, LVL_W = 6, PW_W = 12, TRY_W = 8, VCYC = 4, DEFPW = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic              cmd_custom = 1'b0, cmd_fixed = 1'b0;
  logic [LVL_W-1:0]  cmd_wl_min = '0, cmd_wl_max = '0, cmd_rail_min = '0, cmd_rail_max = '0;
  logic [PW_W-1:0]   cmd_pulse_cycles = '0;
  logic [TRY_W-1:0]  cmd_tries = '0;
  logic              verify_pass;
  logic [LVL_W-1:0]  wl_code, bl_code, sl_code;
  logic              pulse_en, verify_en, done, fail;
  logic [ADDR_W-1:0] cell_addr;

  int vectors = 0, misses = 0;
  int pulses_seen = 0, base = 0;
  int e_op, e_fixed, e_wlmin, e_wlmax, e_smin, e_smax, e_pw, e_pass;
  bit finished = 0;

  assign verify_pass = (e_pass != 0) && ((pulses_seen - base) >= e_pass);

  rram_pulse_seq i_rram_pulse_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_custom(cmd_custom), .cmd_fixed(cmd_fixed),
    .cmd_wl_min(cmd_wl_min), .cmd_wl_max(cmd_wl_max), .cmd_rail_min(cmd_rail_min),
    .cmd_rail_max(cmd_rail_max), .cmd_pulse_cycles(cmd_pulse_cycles), .cmd_tries(cmd_tries),
    .verify_pass(verify_pass), .wl_code(wl_code), .bl_code(bl_code), .sl_code(sl_code),
    .pulse_en(pulse_en), .verify_en(verify_en), .cell_addr(cell_addr), .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: per-pulse levels, widths, gaps and verify timing
  bit prev_pe = 0, prev_ve = 0, prev_zero = 1;
  int pe_run = 0, ve_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_en && !prev_pe) begin
        int k, w, s, ebl, esl, nwl;
        k = pulses_seen - base;
        pulses_seen++;
        nwl = e_wlmax - e_wlmin + 1;
        if (e_fixed != 0) begin w = e_wlmin; s = e_smin; end
        else begin w = e_wlmin + k % nwl; s = e_smin + k / nwl; end
        if (e_op == 2) begin ebl = 0; esl = s; end else begin ebl = s; esl = 0; end
        chk(int'(wl_code) == w, "R3/R4/R6/R11 wl level", int'(wl_code), w);
        chk(int'(bl_code) == ebl, "R2/R4 bl level", int'(bl_code), ebl);
        chk(int'(sl_code) == esl, "R2/R4 sl level", int'(sl_code), esl);
        chk(prev_zero, "R10 gap before pulse", int'(prev_zero), 1);
        pe_run = 1;
      end else if (pulse_en) pe_run++;
      if (!pulse_en && prev_pe) chk(pe_run == e_pw, "R8 pulse width (R6/R7)", pe_run, e_pw);
      if (verify_en && !prev_ve) begin
        chk(prev_pe, "R9 verify right after pulse", int'(prev_pe), 1);
        ve_run = 1;
      end else if (verify_en) ve_run++;
      if (!verify_en && prev_ve) chk(ve_run == VCYC, "R9 verify length", ve_run, VCYC);
      if (!pulse_en && (wl_code != 0 || bl_code != 0 || sl_code != 0))
        chk(0, "R9/R10 rails nonzero outside pulse", int'(wl_code), 0);
    end
    prev_pe   = pulse_en;
    prev_ve   = verify_en;
    prev_zero = (wl_code == 0 && bl_code == 0 && sl_code == 0);
  end

  task automatic run_cmd(input string tag, input int op, input bit custom, input bit fixed,
                         input int wlmin, input int wlmax, input int smin, input int smax,
                         input int pw, input int tries, input int addr, input int pass_at,
                         input bit poke);
    int nexp, nwl, ns, wait_cnt, after;
    if (!custom) begin
      case (op)
        0: begin e_wlmin = 14; e_wlmax = 25; e_smin = 24; e_smax = 33; end
        2: begin e_wlmin = 25; e_wlmax = 25; e_smin = 26; e_smax = 26; end
        default: begin e_wlmin = 17; e_wlmax = 17; e_smin = 24; e_smax = 24; end
      endcase
      e_pw = DEFPW;
    end else begin
      e_wlmin = wlmin; e_wlmax = wlmax; e_smin = smin; e_smax = smax;
      e_pw = (pw == 0) ? 1 : pw;
    end
    e_op = (op == 3) ? 1 : op;
    e_fixed = fixed;
    nwl = e_wlmax - e_wlmin + 1;
    ns  = e_smax - e_smin + 1;
    if (pass_at > 0) nexp = pass_at;
    else if (fixed) nexp = (tries == 0) ? 1 : tries;
    else nexp = nwl * ns;
    @(negedge clk);
    base   = pulses_seen;
    e_pass = pass_at;
    cmd_valid = 1; cmd_op = 2'(op); cmd_custom = custom; cmd_fixed = fixed;
    // ramp fields carry junk when defaults are selected (R6 ignores them)
    cmd_wl_min = custom ? LVL_W'(wlmin) : LVL_W'(1);
    cmd_wl_max = custom ? LVL_W'(wlmax) : LVL_W'(2);
    cmd_rail_min = custom ? LVL_W'(smin) : LVL_W'(3);
    cmd_rail_max = custom ? LVL_W'(smax) : LVL_W'(4);
    cmd_pulse_cycles = custom ? PW_W'(pw) : PW_W'(7);
    cmd_tries = TRY_W'(tries);
    cmd_addr = ADDR_W'(addr);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 0, {"R1 busy after accept ", tag}, int'(cmd_ready), 0);
    chk(done == 0 && fail == 0, {"R12 flags cleared ", tag}, int'(done | fail), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_valid = 1; cmd_op = 2'd2; cmd_addr = ADDR_W'(addr + 1); cmd_custom = 0;
      chk(cmd_ready == 0, {"R1 ready low while busy ", tag}, int'(cmd_ready), 0);
      repeat (6) @(negedge clk);
      cmd_valid = 0;
      chk(int'(cell_addr) == addr, {"R1 address unchanged ", tag}, int'(cell_addr), addr);
    end
    wait_cnt = 0;
    while (!(done || fail) && wait_cnt < 40000) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk(int'(done) == (pass_at > 0), {"R9/R5 done ", tag}, int'(done), int'(pass_at > 0));
    chk(int'(fail) == (pass_at == 0), {"R5/R11 fail ", tag}, int'(fail), int'(pass_at == 0));
    chk(pulses_seen - base == nexp, {"R3/R4/R11 pulse count ", tag}, pulses_seen - base, nexp);
    chk(int'(cell_addr) == addr, {"R12 cell address ", tag}, int'(cell_addr), addr);
    chk(wl_code == 0 && bl_code == 0 && sl_code == 0, {"R5 rails zero at end ", tag},
        int'(wl_code) + int'(bl_code) + int'(sl_code), 0);
    after = pulses_seen;
    repeat (12) @(negedge clk);
    chk(pulses_seen == after, {"R5/R9 no pulse after end ", tag}, pulses_seen - after, 0);
    chk(int'(done) == (pass_at > 0) && int'(fail) == (pass_at == 0) && cmd_ready,
        {"R12 flags held ", tag}, int'(done) * 2 + int'(fail), (pass_at > 0) ? 2 : 1);
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1, "R1 ready after reset", int'(cmd_ready), 1);
    chk(!pulse_en && !verify_en, "R10 strobes low after reset", int'(pulse_en), 0);
    chk(!done && !fail, "R12 flags low after reset", int'(done | fail), 0);
    chk(wl_code == 0 && bl_code == 0 && sl_code == 0, "R2 rails zero after reset", int'(wl_code), 0);
  endtask

  task automatic t_form_default_first;  run_cmd("form_def1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1, 0); endtask
  task automatic t_form_default_wrap;   run_cmd("form_wrap", 0, 0, 0, 0, 0, 0, 0, 0, 0, 6, 13, 0); endtask
  task automatic t_form_custom_sweep;   run_cmd("form_sweep", 0, 1, 0, 3, 5, 10, 11, 25, 0, 7, 5, 0); endtask
  task automatic t_form_exhaust;        run_cmd("form_exh", 0, 1, 0, 3, 4, 10, 11, 30, 0, 8, 0, 0); endtask
  task automatic t_set_default_pass;    run_cmd("set_def", 1, 0, 0, 0, 0, 0, 0, 0, 0, 9, 1, 0); endtask
  task automatic t_set_default_fail;    run_cmd("set_fail", 1, 0, 0, 0, 0, 0, 0, 0, 0, 10, 0, 0); endtask
  task automatic t_reset_default;       run_cmd("rst_def", 2, 0, 0, 0, 0, 0, 0, 0, 0, 11, 1, 0); endtask
  task automatic t_reset_ramp;          run_cmd("rst_ramp", 2, 1, 0, 25, 26, 24, 25, 50, 0, 12, 3, 0); endtask
  task automatic t_fixed_pass;          run_cmd("fix_pass", 0, 1, 1, 7, 9, 9, 12, 20, 4, 13, 3, 0); endtask
  task automatic t_fixed_fail;          run_cmd("fix_fail", 2, 1, 1, 7, 9, 9, 12, 20, 4, 14, 0, 0); endtask
  task automatic t_busy_ignore;         run_cmd("busy", 0, 1, 0, 3, 5, 10, 11, 40, 0, 15, 4, 1); endtask

  initial begin
    e_op = 0; e_fixed = 0; e_wlmin = 0; e_wlmax = 0; e_smin = 0; e_smax = 0; e_pw = 1; e_pass = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_form_default_first;
    t_form_default_wrap;
    t_form_custom_sweep;
    t_form_exhaust;
    t_set_default_pass;
    t_set_default_fail;
    t_reset_default;
    t_reset_ramp;
    t_fixed_pass;
    t_fixed_fail;
    t_busy_ignore;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule